// File: doc/BRIEF.md
# Strided Stream Channel with Address Repeater and Data Queue

This block moves one stream of words between an external memory and a pipelined compute array. Addresses are supplied as compact descriptors: a start address, a repeat count and a stride. A repeater turns each descriptor into a run of addresses, adding the stride after every issued address. This lets one descriptor stand for many memory accesses, so the address source needs far less than one entry per cycle.

A 16-entry data queue sits between memory and the array. With `dir_write` low the channel is an input stream: it issues read requests, stores the returned words in the queue, and the array takes words out when its pop control bit is set. With `dir_write` high it is an output stream: the array pushes words in with its push control bit, and the channel issues one memory write per queued word, pairing it with the next address. A read request goes out only when the queue has room for every read already in flight plus the new one, so returned data never has to be dropped.

When the array asks to pop from an empty queue or to push into a full one, `halt` is raised in the same cycle so the whole array can stall; the access is retried once the queue changes. `dir_write` is a static setting and changes only while `rst_n` is low.

Top module: `ssg_stream`

## Requirements
- R1: After reset `mem_req`, `halt` and `done` are low and `desc_ready` is high.
- R2: A descriptor with count N of at least 1 produces exactly N memory requests with addresses base + k*stride modulo 2^AW for k = 0..N-1, in that order; descriptors are served in the order they are accepted.
- R3: A descriptor with count zero produces no request; if it carries the last flag, the channel still ends its sequence.
- R4: In input mode, read data returns in request order, is queued, and `arr_rdata` shows the oldest queued word; each pop granted without `halt` removes it, so the array sees data in address order.
- R5: In input mode a read is requested only while the queued words plus reads in flight plus one do not exceed the queue depth of 16.
- R6: In output mode a write is requested only while the queue holds a word; each granted write carries the next address and the oldest pushed word.
- R7: In input mode, `arr_pop` with an empty queue raises `halt` in the same cycle and removes nothing.
- R8: In output mode, `arr_push` with a full queue raises `halt` in the same cycle and the word is not stored.
- R9: `arr_pop` has no effect in output mode and `arr_push` has no effect in input mode: neither raises `halt` nor changes the queue.
- R10: `done` rises in the cycle after the last address is granted (or a last zero-count descriptor is accepted), and in output mode only once the queue is empty; once the last descriptor is taken `desc_ready` stays low.
- R11: A request that is not granted stays asserted with the same address in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_write | input | 1 | 0: input stream (memory reads), 1: output stream (memory writes) |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Channel accepts a descriptor this cycle |
| desc_base | input | AW | Start address of the run |
| desc_count | input | CW | Number of addresses in the run |
| desc_stride | input | AW | Increment added after each address |
| desc_last | input | 1 | Marks the final descriptor |
| arr_pop | input | 1 | Array control bit: take one word (input mode) |
| arr_rdata | output | DW | Oldest queued word |
| arr_push | input | 1 | Array control bit: store one word (output mode) |
| arr_wdata | input | DW | Word to store |
| halt | output | 1 | Stall request for the array |
| done | output | 1 | Sequence finished |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request address |
| mem_wdata | output | DW | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data returned this cycle |
| mem_rdata | input | DW | Returned read data |

## Verification
`halt` follows the array's control bits within the same cycle, so the bench changes `arr_pop` or `arr_push` on the falling edge and reads `halt` one time step later, before the next rising edge. `mem_req` and `mem_addr` come from registered state only, so the memory model grants on the falling edge and the queued word, the next address and the credit count move at the following rising edge; a popped word is taken from `arr_rdata` in the same half cycle the pop is driven. `done` is due one edge after the final grant, so the bench counts any falling edge at which `done` is seen before all expected grants were logged, and reads `desc_ready` and `done` a few cycles after each run.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } stream_dir_e;

    // bits needed to hold the values 0..depth
    function automatic int unsigned cnt_bits(int unsigned depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/ssg_repeater.sv
module ssg_repeater #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          desc_valid,
    input  logic [AW-1:0] desc_base,
    input  logic [CW-1:0] desc_count,
    input  logic [AW-1:0] desc_stride,
    input  logic          desc_last,
    input  logic          take,
    output logic          desc_ready,
    output logic          addr_valid,
    output logic [AW-1:0] addr,
    output logic          all_issued
);

    typedef struct packed {
        logic          active;
        logic          last;
        logic          issued;
        logic [CW-1:0] left;
        logic [AW-1:0] addr;
        logic [AW-1:0] stride;
    } rep_t;

    rep_t st_d, st_q;

    assign desc_ready = !st_q.active && !st_q.issued;
    assign addr_valid = st_q.active;
    assign addr       = st_q.addr;
    assign all_issued = st_q.issued;

    always_comb begin
        st_d = st_q;
        if (st_q.active && take) begin
            st_d.addr = st_q.addr + st_q.stride;
            st_d.left = st_q.left - CW'(1);
            if (st_q.left == CW'(1)) begin
                st_d.active = 1'b0;
                st_d.issued = st_q.last;
            end
        end
        if (desc_ready && desc_valid) begin
            if (desc_count == '0) begin
                st_d.issued = desc_last;
            end else begin
                st_d.active = 1'b1;
                st_d.addr   = desc_base;
                st_d.left   = desc_count;
                st_d.stride = desc_stride;
                st_d.last   = desc_last;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: an address is consumed only while a run is in progress
    p_take_in_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> st_q.active);

    // R10: the end of the sequence is never withdrawn
    p_issued_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.issued |=> st_q.issued);

    // R11: an address not consumed is offered again unchanged
    p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active && !take |=> st_q.active && $stable(st_q.addr));

endmodule

// File: rtl/ssg_fifo.sv
module ssg_fifo #(
    parameter int  DW    = 16,
    parameter int  DEPTH = 16,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW  = ssg_pkg::cnt_bits(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [DW-1:0]   wdata,
    input  logic            pop,
    output logic [DW-1:0]   head,
    output logic [CNTW-1:0] count,
    output logic            empty,
    output logic            full
);

    typedef struct packed {
        logic [PW-1:0]   wr;
        logic [PW-1:0]   rd;
        logic [CNTW-1:0] cnt;
    } fifo_t;

    fifo_t st_d, st_q;
    logic [DW-1:0] store_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == CNTW'(DEPTH));
    assign count   = st_q.cnt;
    assign head    = store_q[st_q.rd];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wr = bump(st_q.wr);
        if (do_pop)  st_d.rd = bump(st_q.rd);
        st_d.cnt = st_q.cnt + CNTW'(do_push) - CNTW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) store_q[st_q.wr] <= wdata;
    end

    // R5: occupancy never leaves 0..DEPTH
    p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNTW'(DEPTH));

    // R8: a push into a full queue leaves it full and unchanged
    p_full_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop |=> full && $stable(st_q.wr));

    // R7: a pop from an empty queue leaves it empty
    p_empty_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        empty && pop && !push |=> empty && $stable(st_q.rd));

endmodule

// File: rtl/ssg_mem_if.sv
module ssg_mem_if #(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    parameter int CNTW  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dir_write,
    input  logic            addr_valid,
    input  logic [AW-1:0]   addr,
    input  logic [CNTW-1:0] fifo_count,
    input  logic            fifo_empty,
    input  logic [DW-1:0]   fifo_head,
    input  logic            mem_gnt,
    input  logic            mem_rvalid,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            take,
    output logic            drain_pop
);

    localparam logic [CNTW:0] LIMIT = (CNTW + 1)'(DEPTH);

    typedef struct packed {
        logic [CNTW-1:0] outst;
    } cred_t;

    cred_t st_d, st_q;
    logic [CNTW:0] need;
    logic room_ok, rd_take;

    assign need      = {1'b0, st_q.outst} + {1'b0, fifo_count} + (CNTW + 1)'(1);
    assign room_ok   = (need <= LIMIT);
    assign mem_req   = addr_valid && (dir_write ? !fifo_empty : room_ok);
    assign mem_we    = dir_write;
    assign mem_addr  = addr;
    assign mem_wdata = fifo_head;
    assign take      = mem_req && mem_gnt;
    assign drain_pop = take && dir_write;
    assign rd_take   = take && !dir_write;

    always_comb begin
        st_d       = st_q;
        st_d.outst = st_q.outst + CNTW'(rd_take) - CNTW'(mem_rvalid);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: data only returns for a read still in flight
    p_rsp_expected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |-> (st_q.outst != '0));

    // R5: reads in flight plus queued words fit in the queue
    p_credit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, st_q.outst} + {1'b0, fifo_count}) <= LIMIT);

    // R11: an ungranted request persists with the same address
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

endmodule

// File: rtl/ssg_stream.sv
module ssg_stream #(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int CW    = 8,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dir_write,
    input  logic          desc_valid,
    output logic          desc_ready,
    input  logic [AW-1:0] desc_base,
    input  logic [CW-1:0] desc_count,
    input  logic [AW-1:0] desc_stride,
    input  logic          desc_last,
    input  logic          arr_pop,
    output logic [DW-1:0] arr_rdata,
    input  logic          arr_push,
    input  logic [DW-1:0] arr_wdata,
    output logic          halt,
    output logic          done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata
);

    import ssg_pkg::*;

    localparam int CNTW = cnt_bits(DEPTH);

    stream_dir_e     dir;
    logic            addr_valid, take, drain_pop, all_issued;
    logic [AW-1:0]   gen_addr;
    logic            q_push, q_pop, q_empty, q_full;
    logic [DW-1:0]   q_wdata, q_head;
    logic [CNTW-1:0] q_count;

    assign dir = stream_dir_e'(dir_write);

    ssg_repeater #(.AW(AW), .CW(CW)) i_rep (
        .clk         (clk),
        .rst_n       (rst_n),
        .desc_valid  (desc_valid),
        .desc_base   (desc_base),
        .desc_count  (desc_count),
        .desc_stride (desc_stride),
        .desc_last   (desc_last),
        .take        (take),
        .desc_ready  (desc_ready),
        .addr_valid  (addr_valid),
        .addr        (gen_addr),
        .all_issued  (all_issued)
    );

    always_comb begin
        if (dir == DIR_WRITE) begin
            q_push  = arr_push;
            q_wdata = arr_wdata;
            q_pop   = drain_pop;
            halt    = arr_push && q_full;
        end else begin
            q_push  = mem_rvalid;
            q_wdata = mem_rdata;
            q_pop   = arr_pop;
            halt    = arr_pop && q_empty;
        end
    end

    ssg_fifo #(.DW(DW), .DEPTH(DEPTH)) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .wdata (q_wdata),
        .pop   (q_pop),
        .head  (q_head),
        .count (q_count),
        .empty (q_empty),
        .full  (q_full)
    );

    ssg_mem_if #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .CNTW(CNTW)) i_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_write  (dir_write),
        .addr_valid (addr_valid),
        .addr       (gen_addr),
        .fifo_count (q_count),
        .fifo_empty (q_empty),
        .fifo_head  (q_head),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .take       (take),
        .drain_pop  (drain_pop)
    );

    assign arr_rdata = q_head;
    assign done      = all_issued && ((dir == DIR_READ) || q_empty);

    // R9: a stall is only ever raised by the control bit that belongs to the mode
    p_halt_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (dir_write ? arr_push : arr_pop));

    // R5: returned read data always finds a free slot
    p_rsp_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_write && mem_rvalid) |-> !q_full);

    // R10: a finished output stream has nothing left to write
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

endmodule

// File: tb/test_ssg_stream.sv
module test_ssg_stream;

    localparam int AW = 16, DW = 16, CW = 8, DEPTH = 16;

    logic          clk, rst_n, dir_write;
    logic          desc_valid, desc_ready, desc_last;
    logic [AW-1:0] desc_base, desc_stride;
    logic [CW-1:0] desc_count;
    logic          arr_pop, arr_push, halt, done;
    logic [DW-1:0] arr_rdata, arr_wdata;
    logic          mem_req, mem_we, mem_gnt, mem_rvalid;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    ssg_stream #(.AW(AW), .DW(DW), .CW(CW), .DEPTH(DEPTH)) i_ssg_stream (
        .clk(clk), .rst_n(rst_n), .dir_write(dir_write),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_base(desc_base),
        .desc_count(desc_count), .desc_stride(desc_stride), .desc_last(desc_last),
        .arr_pop(arr_pop), .arr_rdata(arr_rdata), .arr_push(arr_push),
        .arr_wdata(arr_wdata), .halt(halt), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mdata(logic [AW-1:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3C5A;
    endfunction

    function automatic logic [DW-1:0] wval(int i);
        return 16'hA000 + 16'(i * 7);
    endfunction

    // descriptors and expected address list
    logic [AW-1:0] db [8];
    logic [CW-1:0] dc [8];
    logic [AW-1:0] ds [8];
    int nd;
    logic [AW-1:0] exp_addr [256];
    int nexp;

    // memory model state and logs
    bit gnt_on, hold, stutter;
    int cyc = 0;
    logic [AW-1:0] rq [256];
    int rq_wr, rq_rd;
    logic [AW-1:0] log_addr [256];
    logic [DW-1:0] log_data [256];
    logic          log_we   [256];
    int nlog, premature, hold_viol;
    bit prev_wait;
    logic [AW-1:0] prev_addr;
    logic [DW-1:0] pop_data [256];
    int npop;

    initial begin
        mem_gnt = 0; mem_rvalid = 0; mem_rdata = '0; prev_wait = 0; prev_addr = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst_n) prev_wait = 0;
            else begin
                if (done && nlog < nexp) premature++;
                if (prev_wait && (!mem_req || mem_addr != prev_addr)) hold_viol++;
            end
            mem_rvalid = 0;
            mem_gnt = 0;
            if (!hold && rq_rd < rq_wr) begin
                mem_rvalid = 1;
                mem_rdata = mdata(rq[rq_rd]);
                rq_rd++;
            end
            if (mem_req && gnt_on && !(stutter && (cyc % 3 == 0))) begin
                mem_gnt = 1;
                log_addr[nlog] = mem_addr;
                log_data[nlog] = mem_wdata;
                log_we[nlog] = mem_we;
                nlog++;
                if (!mem_we) begin
                    rq[rq_wr] = mem_addr;
                    rq_wr++;
                end
            end
            prev_wait = rst_n && mem_req && !mem_gnt;
            prev_addr = mem_addr;
        end
    end

    task automatic reset_dut(bit wr);
        @(negedge clk);
        rst_n = 0; dir_write = wr;
        desc_valid = 0; desc_base = '0; desc_count = '0; desc_stride = '0; desc_last = 0;
        arr_pop = 0; arr_push = 0; arr_wdata = '0;
        gnt_on = 0; hold = 1; stutter = 0;
        rq_wr = 0; rq_rd = 0; nlog = 0; npop = 0; premature = 0; hold_viol = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic build_exp();
        nexp = 0;
        for (int i = 0; i < nd; i++)
            for (int k = 0; k < int'(dc[i]); k++) begin
                exp_addr[nexp] = 16'(int'(db[i]) + k * int'(ds[i]));
                nexp++;
            end
    endtask

    task automatic feed_desc();
        for (int i = 0; i < nd; i++) begin
            int guard = 0;
            @(negedge clk);
            desc_valid = 1; desc_base = db[i]; desc_count = dc[i];
            desc_stride = ds[i]; desc_last = (i == nd - 1);
            while (!desc_ready && guard < 5000) begin
                @(negedge clk);
                guard++;
            end
        end
        @(negedge clk);
        desc_valid = 0;
    endtask

    task automatic pop_all(int n, int pattern);
        int guard = 0;
        while (npop < n && guard < 20000) begin
            @(negedge clk);
            arr_pop = (pattern == 0) || (guard % pattern == 0);
            #1;
            if (arr_pop && !halt) begin
                pop_data[npop] = arr_rdata;
                npop++;
            end
            guard++;
        end
        @(negedge clk);
        arr_pop = 0;
    endtask

    task automatic push_all(int n, int pattern, bit expect_no_halt);
        int i = 0, guard = 0, halts = 0;
        while (i < n && guard < 20000) begin
            @(negedge clk);
            arr_push = (pattern == 0) || (guard % pattern == 0);
            arr_wdata = wval(i);
            #1;
            if (arr_push) begin
                if (halt) halts++;
                else i++;
            end
            guard++;
        end
        @(negedge clk);
        arr_push = 0;
        if (expect_no_halt) chk(halts == 0, "R8 no stall below full", halts, 0);
    endtask

    task automatic check_log(bit wr, string tag);
        chk(nlog == nexp, {tag, " request count"}, nlog, nexp);
        for (int i = 0; i < nexp && i < nlog; i++) begin
            chk(log_addr[i] == exp_addr[i], {tag, " R2 address"}, log_addr[i], exp_addr[i]);
            chk(log_we[i] == wr, {tag, " R6 write flag"}, log_we[i], wr);
            if (wr) chk(log_data[i] == wval(i), {tag, " R6 write data"}, log_data[i], wval(i));
        end
        chk(premature == 0, {tag, " R10 early done"}, premature, 0);
        chk(hold_viol == 0, {tag, " R11 request hold"}, hold_viol, 0);
        chk(done == 1'b1, {tag, " R10 done"}, done, 1);
        chk(desc_ready == 1'b0, {tag, " R10 ready low"}, desc_ready, 0);
    endtask

    task automatic run_input(int pattern, bit stut, string tag);
        reset_dut(0);
        build_exp();
        gnt_on = 1; hold = 0; stutter = stut;
        fork
            feed_desc();
            pop_all(nexp, pattern);
        join
        repeat (3) @(negedge clk);
        check_log(0, tag);
        for (int i = 0; i < nexp && i < npop; i++)
            chk(pop_data[i] == mdata(exp_addr[i]), {tag, " R4 pop data"}, pop_data[i], mdata(exp_addr[i]));
    endtask

    task automatic run_output(int pattern, bit stut, string tag);
        int guard = 0;
        reset_dut(1);
        build_exp();
        gnt_on = 1; hold = 1; stutter = stut;
        fork
            feed_desc();
            push_all(nexp, pattern, 0);
        join
        while (nlog < nexp && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
        check_log(1, tag);
    endtask

    logic [AW-1:0] strides [4];

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        strides[0] = 16'h0000; strides[1] = 16'h0001;
        strides[2] = 16'h0003; strides[3] = 16'hFFFE;
        nexp = 0;

        // R1: reset state
        reset_dut(0);
        chk(mem_req == 0, "R1 mem_req", mem_req, 0);
        chk(halt == 0, "R1 halt", halt, 0);
        chk(done == 0, "R1 done", done, 0);
        chk(desc_ready == 1, "R1 desc_ready", desc_ready, 1);

        // R2/R4: sweep of counts and strides, wrapping base
        for (int c = 1; c <= 5; c++)
            for (int s = 0; s < 4; s++) begin
                nd = 1; db[0] = 16'hFFF8; dc[0] = CW'(c); ds[0] = strides[s];
                run_input(c % 3, 0, "sweep");
            end

        // R2/R3: several runs, a zero-count run in the middle, stuttering grants
        nd = 4;
        db[0] = 16'h0100; dc[0] = 5; ds[0] = 16'h0004;
        db[1] = 16'h2000; dc[1] = 0; ds[1] = 16'h0001;
        db[2] = 16'hFFF0; dc[2] = 3; ds[2] = 16'h0010;
        db[3] = 16'h0040; dc[3] = 4; ds[3] = 16'hFFFF;
        run_input(2, 1, "R3 multi");

        // R3: last descriptor has count zero, sequence still ends
        nd = 2;
        db[0] = 16'h0700; dc[0] = 3; ds[0] = 16'h0002;
        db[1] = 16'h0900; dc[1] = 0; ds[1] = 16'h0005;
        run_input(0, 0, "R3 zero last");

        // R5/R7/R9: credit limit with responses held back
        reset_dut(0);
        nd = 1; db[0] = 16'h0500; dc[0] = 20; ds[0] = 16'h0001;
        build_exp();
        gnt_on = 1;
        feed_desc();
        repeat (30) @(negedge clk);
        chk(nlog == DEPTH, "R5 reads in flight", nlog, DEPTH);
        chk(mem_req == 0, "R5 request withheld", mem_req, 0);
        arr_pop = 1; #1;
        chk(halt == 1, "R7 pop empty stalls", halt, 1);
        @(negedge clk); arr_pop = 0;
        hold = 0;
        repeat (25) @(negedge clk);
        chk(nlog == DEPTH, "R5 no read while full", nlog, DEPTH);
        arr_push = 1; arr_wdata = 16'hDEAD; #1;
        chk(halt == 0, "R9 push ignored in input mode", halt, 0);
        @(negedge clk); arr_push = 0;
        pop_all(20, 0);
        repeat (3) @(negedge clk);
        chk(nlog == 20, "R5 all reads issued", nlog, 20);
        for (int i = 0; i < 20; i++)
            chk(pop_data[i] == mdata(exp_addr[i]), "R4 R9 data order", pop_data[i], mdata(exp_addr[i]));

        // R6/R8/R9: output stream fills, stalls, then drains
        reset_dut(1);
        nd = 2;
        db[0] = 16'h0300; dc[0] = 10; ds[0] = 16'h0002;
        db[1] = 16'h0800; dc[1] = 6;  ds[1] = 16'h0003;
        build_exp();
        arr_pop = 1; #1;
        chk(halt == 0, "R9 pop ignored in output mode", halt, 0);
        @(negedge clk); arr_pop = 0;
        chk(mem_req == 0, "R6 no write while empty", mem_req, 0);
        push_all(DEPTH, 0, 1);
        arr_push = 1; arr_wdata = 16'hBEEF; #1;
        chk(halt == 1, "R8 push full stalls", halt, 1);
        @(negedge clk); arr_push = 0;
        gnt_on = 1;
        feed_desc();
        repeat (30) @(negedge clk);
        check_log(1, "R6 R8 drain");

        // R6: output streams with different push and grant patterns
        nd = 1; db[0] = 16'h1000; dc[0] = 12; ds[0] = 16'h0004;
        run_output(0, 0, "R6 out steady");
        nd = 2;
        db[0] = 16'hFFFC; dc[0] = 6; ds[0] = 16'h0002;
        db[1] = 16'h0020; dc[1] = 7; ds[1] = 16'hFFFD;
        run_output(3, 1, "R6 out sparse");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule